// File: doc/BRIEF.md
# Fourth-Order Fixed-Point IIR Low-Pass Filter

This block is a low-pass filter for a demodulated sample stream. It takes one 16-bit signed sample on every clock and returns one filtered 16-bit signed sample on every clock. Its purpose is to remove the residue of a 3.125 MHz modulation tone, and of that tone's second harmonic, from a 100 MHz sample stream after mixing. It is built from two second-order recursive sections placed one after the other. Each section keeps its past inputs and past outputs in separate delay registers. A register between the sections splits the long multiply-add path, so each clock period holds only one section's arithmetic.

In each section the two outer numerator coefficients are fixed at one. Those two terms are therefore a plain shift into the accumulator and use no multiplier. The three remaining coefficients of each section are held in registers, in a signed format with two integer bits and fourteen fraction bits. Reset loads a default low-pass design into them. Software can overwrite any of the six words one at a time through a small write port. Each section clips its result to the 16-bit range before the result goes back into its own feedback path.

Top module: `iir_lp4_cascade`

## Requirements
- R1: Each section forms acc = 2^14·u[k] + b·u[k−1] + 2^14·u[k−2] − d·y[k−1] − e·y[k−2], where b, d and e are signed Q2.14 words. It keeps at least 34 bits and arithmetic-shifts acc right by 14, which rounds toward minus infinity. The result is y[k]. The output of the first section is the input u of the second.
- R2: A new sample is accepted on every clock. A sample present on x_in at rising edge k affects y_out first after rising edge k+3, and y_out holds the filter output for that sample from then until edge k+4.
- R3: After reset the coefficients are, in Q2.14: first section b = −30274, d = −29787, e = 13717; second section b = −32139, d = −31939, e = 16058.
- R4: The unit outer numerator terms need no coefficient. With all six loaded coefficients set to 0, the output sequence equals x[k] + 2·x[k−2] + x[k−4].
- R5: Each section clips its shifted result to the range −32768 to 32767. It then stores the clipped value as y[k−1] and passes it on.
- R6: When coef_we is high at a rising edge, coef_data is written into slot coef_idx. Slot 3·s+0 holds b, slot 3·s+1 holds d and slot 3·s+2 holds e of section s, where s = 0 is the first section. The new word is used from the next edge on.
- R7: A write with coef_idx equal to 6 or 7 changes no coefficient.
- R8: A synchronous reset (rst high at a rising edge) clears the input register, all four delay registers of both sections and the inter-section register. After that edge y_out is 0. Reset also restores the coefficients of R3.
- R9: With the default coefficients, a sine of amplitude 1000 at one thirty-second of the sample rate gives |y_out| ≤ 500 once 2000 samples have passed. A constant input of the same size gives an output near 9900.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 3 | Coefficient slot selector (0 to 5 valid) |
| coef_data | input | 16 | Signed Q2.14 coefficient word |
| x_in | input | 16 | Signed input sample |
| y_out | output | 16 | Signed filtered sample, registered |

## Verification
The assertions take three things for granted. Reset must be high at the first rising edge. coef_idx and coef_data must carry defined values whenever coef_we is high. Coefficient writes must be single-cycle strobes, because the checks compare a slot with the word one edge earlier. The stimulus holds reset from time zero and drives the write bus only through a task that sets all three fields at once and drops the strobe on the following cycle. It also writes coefficients only straight after a reset, while the delay registers are zero. This way a change of coefficient never lands in the middle of a sample moving through the two sections.

// File: rtl/iir_lp4_pkg.sv
package iir_lp4_pkg;

  localparam int DEF_SAMPLE_W = 16;
  localparam int DEF_COEF_W   = 16;
  localparam int DEF_FRAC     = 14;
  localparam int DEF_ACC_W    = 34;
  localparam int SLOTS_PER_SECT = 3;

  typedef enum logic [1:0] {
    SLOT_B = 2'd0,
    SLOT_D = 2'd1,
    SLOT_E = 2'd2
  } coef_slot_e;

  // Default low-pass design in Q2.14; sections past the second reuse the second.
  function automatic logic signed [DEF_COEF_W-1:0] default_coef(input int sect, input int slot);
    logic signed [DEF_COEF_W-1:0] v;
    if (sect == 0) begin
      case (slot)
        0:       v = -16'sd30274;
        1:       v = -16'sd29787;
        default: v =  16'sd13717;
      endcase
    end else begin
      case (slot)
        0:       v = -16'sd32139;
        1:       v = -16'sd31939;
        default: v =  16'sd16058;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/iir_coef_bank.sv
module iir_coef_bank
  import iir_lp4_pkg::*;
#(
  parameter int NUM_SECT = 2,
  parameter int COEF_W   = DEF_COEF_W,
  parameter bit LOAD_EN  = 1'b1,
  localparam int NWORDS  = SLOTS_PER_SECT * NUM_SECT,
  localparam int IDX_W   = $clog2(NWORDS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [IDX_W-1:0]              idx,
  input  logic [COEF_W-1:0]             data,
  output logic [NWORDS-1:0][COEF_W-1:0] coef_o
);

  function automatic logic [NWORDS-1:0][COEF_W-1:0] build_defaults();
    logic [NWORDS-1:0][COEF_W-1:0] v;
    for (int w = 0; w < NWORDS; w++) begin
      v[w] = COEF_W'(default_coef(w / SLOTS_PER_SECT, w % SLOTS_PER_SECT));
    end
    return v;
  endfunction

  localparam logic [NWORDS-1:0][COEF_W-1:0] DEF_VEC = build_defaults();

  generate
    if (LOAD_EN) begin : g_loadable
      logic [NWORDS-1:0][COEF_W-1:0] coef_q;
      logic                          idx_ok;

      assign idx_ok = ({1'b0, idx} < (IDX_W+1)'(NWORDS));

      always_ff @(posedge clk) begin
        if (rst) begin
          coef_q <= DEF_VEC;
        end else if (we && idx_ok) begin
          coef_q[idx] <= data;
        end
      end

      assign coef_o = coef_q;

      // R6
      load_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (we && idx_ok) |=> (coef_q[$past(idx)] == $past(data)));

      // R7
      bad_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !idx_ok) |=> $stable(coef_q));

      // R8
      reset_default_chk: assert property (@(posedge clk)
        rst |=> (coef_q == DEF_VEC));
    end else begin : g_fixed
      assign coef_o = DEF_VEC;
    end
  endgenerate

endmodule

// File: rtl/iir_df1_section.sv
module iir_df1_section #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC   = 14,
  parameter int ACC_W  = 34
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] u_in,
  input  logic signed [COEF_W-1:0] coef_b,
  input  logic signed [COEF_W-1:0] coef_d,
  input  logic signed [COEF_W-1:0] coef_e,
  output logic signed [DATA_W-1:0] y_q
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam logic signed [ACC_W-1:0] SAT_HI =
    {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO =
    {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] OUT_HI = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] OUT_LO = {1'b1, {(DATA_W-1){1'b0}}};

  // Delay line: past inputs and past (clipped) outputs.
  logic signed [DATA_W-1:0] u1_q, u2_q, y2_q;
  logic signed [PROD_W-1:0] p_b, p_d, p_e;
  logic signed [ACC_W-1:0]  t_now, t_old, acc, acc_sh;
  logic signed [DATA_W-1:0] y_next;
  logic                     armed;

  always_comb begin
    // Unit outer numerator terms: shifts, no multiplier.
    t_now  = ACC_W'(u_in) <<< FRAC;
    t_old  = ACC_W'(u2_q) <<< FRAC;
    p_b    = PROD_W'(coef_b) * PROD_W'(u1_q);
    p_d    = PROD_W'(coef_d) * PROD_W'(y_q);
    p_e    = PROD_W'(coef_e) * PROD_W'(y2_q);
    acc    = t_now + t_old + ACC_W'(p_b) - ACC_W'(p_d) - ACC_W'(p_e);
    acc_sh = acc >>> FRAC;
    if (acc_sh > SAT_HI) begin
      y_next = OUT_HI;
    end else if (acc_sh < SAT_LO) begin
      y_next = OUT_LO;
    end else begin
      y_next = acc_sh[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u1_q <= '0;
      u2_q <= '0;
      y_q  <= '0;
      y2_q <= '0;
    end else begin
      u1_q <= u_in;
      u2_q <= u1_q;
      y_q  <= y_next;
      y2_q <= y_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R8
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (u1_q == '0 && u2_q == '0 && y_q == '0 && y2_q == '0));

  // R1
  delay_line_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (u2_q == $past(u1_q)) && (y2_q == $past(y_q)));

endmodule

// File: rtl/iir_lp4_cascade.sv
module iir_lp4_cascade
  import iir_lp4_pkg::*;
#(
  parameter int NUM_SECT = 2,
  parameter int DATA_W   = DEF_SAMPLE_W,
  parameter int COEF_W   = DEF_COEF_W,
  parameter int FRAC     = DEF_FRAC,
  parameter int ACC_W    = DEF_ACC_W,
  parameter bit LOAD_EN  = 1'b1,
  localparam int NWORDS  = SLOTS_PER_SECT * NUM_SECT,
  localparam int IDX_W   = $clog2(NWORDS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     coef_we,
  input  logic [IDX_W-1:0]         coef_idx,
  input  logic [COEF_W-1:0]        coef_data,
  input  logic signed [DATA_W-1:0] x_in,
  output logic signed [DATA_W-1:0] y_out
);

  logic signed [DATA_W-1:0]      x_q;
  logic signed [DATA_W-1:0]      sect_in  [NUM_SECT];
  logic signed [DATA_W-1:0]      sect_out [NUM_SECT];
  logic [NWORDS-1:0][COEF_W-1:0] coef_vec;
  logic                          armed;

  always_ff @(posedge clk) begin
    if (rst) x_q <= '0;
    else     x_q <= x_in;
  end

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  iir_coef_bank #(
    .NUM_SECT (NUM_SECT),
    .COEF_W   (COEF_W),
    .LOAD_EN  (LOAD_EN)
  ) coef_bank_i (
    .clk    (clk),
    .rst    (rst),
    .we     (coef_we),
    .idx    (coef_idx),
    .data   (coef_data),
    .coef_o (coef_vec)
  );

  assign sect_in[0] = x_q;

  generate
    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
      localparam int BASE = SLOTS_PER_SECT * s;

      iir_df1_section #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .FRAC   (FRAC),
        .ACC_W  (ACC_W)
      ) section_i (
        .clk    (clk),
        .rst    (rst),
        .u_in   (sect_in[s]),
        .coef_b (coef_vec[BASE + int'(SLOT_B)]),
        .coef_d (coef_vec[BASE + int'(SLOT_D)]),
        .coef_e (coef_vec[BASE + int'(SLOT_E)]),
        .y_q    (sect_out[s])
      );

      if (s < NUM_SECT - 1) begin : g_pipe
        logic signed [DATA_W-1:0] pipe_q;

        always_ff @(posedge clk) begin
          if (rst) pipe_q <= '0;
          else     pipe_q <= sect_out[s];
        end

        assign sect_in[s+1] = pipe_q;

        // R2
        stage_pipe_chk: assert property (@(posedge clk) disable iff (rst || !armed)
          pipe_q == $past(sect_out[s]));
      end
    end
  endgenerate

  assign y_out = sect_out[NUM_SECT-1];

  // R2
  input_reg_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    x_q == $past(x_in));

  // R8
  out_reset_chk: assert property (@(posedge clk)
    rst |=> (y_out == '0));

endmodule

// File: tb/iir_lp4_cascade_tb_top.sv
module iir_lp4_cascade_tb_top;

  localparam int DW = 16;
  localparam int CW = 16;
  localparam int IW = 3;
  localparam int NV = 12;

  // Unit-numerator check (all loaded coefficients zero): y = x[k] + 2x[k-2] + x[k-4].
  localparam int VIN  [NV] = '{100, 0, 0, 0, 0, 0, -50, 0, 0, 0, 7, 3};
  localparam int VEXP [NV] = '{100, 0, 200, 0, 100, 0, -50, 0, -100, 0, -43, 3};

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 coef_we = 1'b0;
  logic [IW-1:0]        coef_idx = '0;
  logic [CW-1:0]        coef_data = '0;
  logic signed [DW-1:0] x_in = '0;
  logic signed [DW-1:0] y_out;

  always #10 clk = ~clk;

  iir_lp4_cascade dut_i (
    .clk       (clk),
    .rst       (rst),
    .coef_we   (coef_we),
    .coef_idx  (coef_idx),
    .coef_data (coef_data),
    .x_in      (x_in),
    .y_out     (y_out)
  );

  int n_cmp = 0;
  int n_bad = 0;

  int mb [2], md [2], me [2];
  int mu1 [2], mu2 [2], my1 [2], my2 [2];
  int hist [4];

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clip16(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic model_defaults();
    mb[0] = -30274; md[0] = -29787; me[0] = 13717;
    mb[1] = -32139; md[1] = -31939; me[1] = 16058;
  endtask

  task automatic model_clear();
    for (int s = 0; s < 2; s++) begin
      mu1[s] = 0; mu2[s] = 0; my1[s] = 0; my2[s] = 0;
    end
    for (int h = 0; h < 4; h++) hist[h] = 0;
  endtask

  function automatic int model_step(input int x);
    int u;
    longint acc;
    int y;
    u = x;
    for (int s = 0; s < 2; s++) begin
      acc = longint'(u) * 16384 + longint'(mu2[s]) * 16384
          + longint'(mb[s]) * mu1[s] - longint'(md[s]) * my1[s]
          - longint'(me[s]) * my2[s];
      y = clip16(acc >>> 14);
      mu2[s] = mu1[s]; mu1[s] = u;
      my2[s] = my1[s]; my1[s] = y;
      u = y;
    end
    return u;
  endfunction

  // One sample per negedge; y_out now shows the sample driven four negedges ago.
  task automatic tick(input int x, input bit chk, input string req);
    @(negedge clk);
    if (chk) check(req, int'(y_out), hist[3]);
    hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0];
    hist[0] = model_step(x);
    x_in = x[DW-1:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; x_in = '0; coef_we = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    model_defaults();
    model_clear();
  endtask

  task automatic write_coef(input int idx, input int val);
    @(negedge clk);
    coef_we = 1'b1; coef_idx = idx[IW-1:0]; coef_data = val[CW-1:0]; x_in = '0;
    @(negedge clk);
    coef_we = 1'b0;
    if (idx < 6) begin
      case (idx % 3)
        0: mb[idx / 3] = val;
        1: md[idx / 3] = val;
        default: me[idx / 3] = val;
      endcase
    end
  endtask

  task automatic zero_coefs();
    for (int w = 0; w < 6; w++) write_coef(w, 0);
  endtask

  task automatic run_table(input string req);
    for (int i = 0; i < NV + 4; i++) begin
      @(negedge clk);
      if (i >= 4) check(req, int'(y_out), VEXP[i-4]);
      x_in = (i < NV) ? VIN[i][DW-1:0] : '0;
    end
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int peak;
    int xs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_defaults();
    model_clear();
    @(negedge clk);
    check("R8 reset state", int'(y_out), 0);

    // R1 R3: default coefficients, moderate step
    for (int i = 0; i < 300; i++) tick(1000, 1'b1, "R1 R3 step");
    for (int i = 0; i < 100; i++) tick(0, 1'b1, "R1 R3 release");

    // R5: step large enough to clip inside the feedback path
    for (int i = 0; i < 200; i++) tick(5000, 1'b1, "R5 clip pos");
    for (int i = 0; i < 200; i++) tick(-5000, 1'b1, "R5 clip neg");

    // R8: reset with state in flight clears everything
    do_reset();
    check("R8 output cleared", int'(y_out), 0);
    for (int i = 0; i < 8; i++) tick(0, 1'b1, "R8 delay regs cleared");

    // R9: tone at the modulation frequency (fs/32)
    peak = 0;
    for (int i = 0; i < 2500; i++) begin
      xs = $rtoi(1000.0 * $sin(2.0 * 3.14159265358979 * i / 32.0));
      tick(xs, 1'b1, "R1 tone");
      if (i >= 2436) begin
        if (int'(y_out) > peak) peak = int'(y_out);
        if (-int'(y_out) > peak) peak = -int'(y_out);
      end
    end
    n_cmp++;
    if (peak > 500) begin
      n_bad++;
      $display("FAIL R9: actual peak %0d expected <= 500", peak);
    end

    // R4 R2: unit numerator terms and exact latency
    do_reset();
    zero_coefs();
    run_table("R4 R2");

    // R7: writes to slots 6 and 7 leave coefficients untouched
    do_reset();
    zero_coefs();
    write_coef(6, 12345);
    write_coef(7, -9000);
    run_table("R7");

    // R5: clipping with zero coefficients, 20000 + 20000 overflows
    do_reset();
    zero_coefs();
    for (int i = 0; i < 10; i++) tick(20000, 1'b1, "R5 clip step");
    check("R5 ceiling", int'(y_out), 32767);
    for (int i = 0; i < 10; i++) tick(-20000, 1'b1, "R5 clip step neg");
    check("R5 floor", int'(y_out), -32768);

    // R6: slot mapping, d of first section and d of second section
    do_reset();
    zero_coefs();
    write_coef(1, -8192);
    write_coef(4, 8192);
    tick(100, 1'b1, "R6 impulse");
    for (int i = 0; i < 24; i++) tick(0, 1'b1, "R6 impulse tail");
    write_coef(0, 16384);
    tick(200, 1'b1, "R6 b slot");
    for (int i = 0; i < 24; i++) tick(0, 1'b1, "R6 b slot tail");

    // R8: reset restores default coefficients
    do_reset();
    for (int i = 0; i < 200; i++) tick(1000, 1'b1, "R8 defaults restored");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule